// File: doc/BRIEF.md
# Two-Stage Pipelined Floating-Point Adder

This block adds or subtracts two IEEE-754 binary32 numbers and returns the rounded sum two cycles later. It accepts a new operation on every clock. Each operation carries two operands, an add/subtract select, a rounding-mode code and a valid strobe. The result comes out with its own valid strobe and with overflow, underflow and inexact flags.

Subnormal operands and subnormal results are handled in hardware at full rate. The block never flushes to zero and has no assist path. The datapath has two paths. The far path covers effective additions and subtractions whose exponents differ by two or more; its result moves by at most one bit. The near path covers effective subtractions whose exponents differ by zero or one; it can cancel many leading bits. The far path builds the sticky bit while it aligns the smaller operand. The near path limits its left shift so the exponent never drops below the smallest normal exponent.

The exponent and fraction widths are parameters, so the same logic can be built at a reduced width.

Top module: `fp_add_pipe`

## Requirements
- R1: An operation presented with `in_valid` high in cycle n gives `out_valid` high with its result in cycle n+2. `out_valid` is low in every cycle not due under this rule, including the cycles after reset. One operation may enter per cycle.
- R2: With `sub` = 1 the block computes `op_a - op_b`. With `sub` = 0 it computes `op_a + op_b`.
- R3: `rnd` = 0 rounds to nearest, with ties going to the even fraction.
- R4: `rnd` = 1 truncates toward zero, `rnd` = 2 rounds toward +infinity and `rnd` = 3 rounds toward -infinity.
- R5: Subnormal operands (exponent field 0) are taken at face value, using an exponent of 1 and a hidden bit of 0, with no flush and no extra latency.
- R6: A sum whose magnitude is below the smallest normal is returned as a subnormal (exponent field 0), not as zero.
- R7: An exact zero sum of two operands with opposite effective signs is -0 when `rnd` = 3 and +0 otherwise. Two zeros with the same effective sign keep that sign.
- R8: When the rounded exponent reaches the all-ones field, `ovf` and `inx` are raised. The result is infinity for `rnd` = 0, and for a directed mode that rounds away from zero in the result's direction. Otherwise the result is the largest finite value with the result's sign.
- R9: `inx` is high exactly when the delivered finite result differs from the exact sum.
- R10: `unf` is high only when the sum before rounding is below the smallest normal and the result is inexact. For this operation such sums are always exact, so `unf` stays low.
- R11: If either operand is a NaN, the result is the quiet NaN with sign 0, exponent all ones and only the fraction MSB set. All flags are low.
- R12: Infinities of opposite effective sign give that same quiet NaN. Any other case with an infinite operand returns that infinity with its effective sign, with all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_a | input | EW+MW+1 | First operand |
| op_b | input | EW+MW+1 | Second operand |
| sub | input | 1 | 1 selects subtraction |
| rnd | input | 2 | Rounding-mode code |
| out_valid | output | 1 | Result strobe |
| result | output | EW+MW+1 | Rounded sum |
| ovf | output | 1 | Overflow flag |
| unf | output | 1 | Underflow flag |
| inx | output | 1 | Inexact flag |

## Verification
Every result and all three flags are due in the second cycle after the cycle the operation was driven. The only exception is the valid strobe in idle cycles, which must stay low.

The bench records the due cycle of each operation in a small queue. It samples the outputs on falling edges and compares them only when the cycle count matches the oldest entry's due cycle. In any cycle with no entry due it requires `out_valid` low. A late, early or missing result is therefore reported as a latency failure, not hidden as a data mismatch.

The bench is built with an 8-bit format (4-bit exponent, 3-bit fraction). It sweeps every operand pair once. It then sweeps the high-exponent region under every rounding mode and both operations. Expected values come from exact integer sums.

// File: rtl/fp_add_pipe.sv
module fp_add_pipe #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [EW+MW:0] op_a,
  input  logic [EW+MW:0] op_b,
  input  logic           sub,
  input  logic [1:0]     rnd,
  output logic           out_valid,
  output logic [EW+MW:0] result,
  output logic           ovf,
  output logic           unf,
  output logic           inx
);
  localparam int W  = EW + MW + 1;
  localparam int MN = MW + 1;
  localparam int X  = MN + 3;
  localparam int DW = $clog2(X + 1);
  localparam int LW = $clog2(MN + 2);
  localparam int SW = (LW > EW) ? LW : EW;
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};
  localparam logic [W-1:0]  QNAN = {1'b0, EMAX, 1'b1, {(MW-1){1'b0}}};

  // ---------------- stage 1: unpack, order, align ----------------
  wire [EW-1:0] ea = op_a[W-2:MW];
  wire [EW-1:0] eb = op_b[W-2:MW];
  wire [MW-1:0] fa = op_a[MW-1:0];
  wire [MW-1:0] fb = op_b[MW-1:0];
  wire          sa = op_a[W-1];
  wire          sb = op_b[W-1] ^ sub;

  wire a_nan = (ea == EMAX) && (fa != {MW{1'b0}});
  wire b_nan = (eb == EMAX) && (fb != {MW{1'b0}});
  wire a_inf = (ea == EMAX) && (fa == {MW{1'b0}});
  wire b_inf = (eb == EMAX) && (fb == {MW{1'b0}});

  wire          swap    = op_b[W-2:0] > op_a[W-2:0];
  wire          eff_sub = sa ^ sb;
  wire          sg      = swap ? sb : sa;
  wire [EW-1:0] eg_r    = swap ? eb : ea;
  wire [EW-1:0] es_r    = swap ? ea : eb;
  wire [MW-1:0] fg      = swap ? fb : fa;
  wire [MW-1:0] fs      = swap ? fa : fb;
  wire [EW-1:0] eg      = (eg_r == {EW{1'b0}}) ? EW'(1) : eg_r;
  wire [EW-1:0] es      = (es_r == {EW{1'b0}}) ? EW'(1) : es_r;
  wire [MN-1:0] mg      = {eg_r != {EW{1'b0}}, fg};
  wire [MN-1:0] ms      = {es_r != {EW{1'b0}}, fs};
  wire [EW-1:0] d       = eg - es;
  wire          near    = eff_sub && (d <= EW'(1));

  // far path: right shift with sticky gathered from the dropped bits
  wire [DW-1:0] dc   = (32'(d) > 32'(X)) ? DW'(X) : DW'(d);
  wire [X-1:0]  sx   = {ms, 3'b000};
  wire [X-1:0]  sxs  = sx >> dc;
  wire          lost = |(sx & ~({X{1'b1}} << dc));
  wire [X-1:0]  al   = {sxs[X-1:1], sxs[0] | lost};
  wire [X:0]    far_c = eff_sub ? ({1'b0, mg, 3'b000} - {1'b0, al})
                                : ({1'b0, mg, 3'b000} + {1'b0, al});

  // near path: at most one bit of alignment, exact with one guard bit
  wire [MN:0] near_c = {mg, 1'b0} - ({ms, 1'b0} >> d[0]);

  wire          spec_c  = a_nan | b_nan | a_inf | b_inf;
  wire [W-1:0]  specv_c = (a_nan || b_nan || (a_inf && b_inf && eff_sub)) ? QNAN :
                          a_inf ? {sa, EMAX, {MW{1'b0}}} : {sb, EMAX, {MW{1'b0}}};

  logic          v1, spec1, near1, effsub1, sg1;
  logic [1:0]    rnd1;
  logic [W-1:0]  specv1;
  logic [EW-1:0] eg1;
  logic [X:0]    far1;
  logic [MN:0]   nd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;

  always_ff @(posedge clk) begin
    spec1   <= spec_c;
    specv1  <= specv_c;
    near1   <= near;
    effsub1 <= eff_sub;
    sg1     <= sg;
    rnd1    <= rnd;
    eg1     <= eg;
    far1    <= far_c;
    nd1     <= near_c;
  end

  // ---------------- stage 2: normalize, round, pack ----------------
  logic [X-1:0]  fn;
  logic [EW:0]   fe;
  logic [LW-1:0] lz;
  logic [SW-1:0] nsh;
  logic [MN:0]   nn;
  logic [EW:0]   ne;
  logic [EW-1:0] lim;

  always_comb begin
    if (far1[X]) begin
      fn = {far1[X:2], far1[1] | far1[0]};
      fe = {1'b0, eg1} + (EW+1)'(1);
    end else if (!effsub1 || far1[X-1]) begin
      fn = far1[X-1:0];
      fe = {1'b0, eg1};
    end else begin
      fn = {far1[X-2:0], 1'b0};
      fe = {1'b0, eg1} - (EW+1)'(1);
    end
  end

  always_comb begin
    lz = LW'(MN + 1);
    for (int i = 0; i <= MN; i++)
      if (nd1[i]) lz = LW'(MN - i);
    lim = eg1 - EW'(1);
    nsh = (32'(lz) > 32'(lim)) ? SW'(lim) : SW'(lz);
    nn  = nd1 << nsh;
    ne  = {1'b0, eg1} - (EW+1)'(nsh);
  end

  wire [MN-1:0] m  = near1 ? nn[MN:1] : fn[X-1:3];
  wire          g  = near1 ? nn[0]    : fn[2];
  wire          st = near1 ? 1'b0     : (fn[1] | fn[0]);
  wire [EW:0]   ex = near1 ? ne       : fe;

  wire zero2 = near1 && (nd1 == {(MN+1){1'b0}});
  wire sr    = zero2 ? (rnd1 == 2'd3) : sg1;
  wire rinc  = (rnd1 == 2'd0) ? (g & (st | m[0])) :
               (rnd1 == 2'd2) ? ((g | st) & ~sr) :
               (rnd1 == 2'd3) ? ((g | st) & sr) : 1'b0;

  wire [MN:0]   m1  = {1'b0, m} + (MN+1)'(1);
  wire [MN-1:0] rm  = !rinc ? m : (m1[MN] ? m1[MN:1] : m1[MN-1:0]);
  wire [EW:0]   rex = (rinc && m1[MN]) ? ex + (EW+1)'(1) : ex;

  wire over   = rex >= {1'b0, EMAX};
  wire inexf  = g | st;
  wire tiny   = !m[MN-1];
  wire to_inf = (rnd1 == 2'd0) || (rnd1 == 2'd2 && !sr) || (rnd1 == 2'd3 && sr);
  wire [W-1:0] ovv = to_inf ? {sr, EMAX, {MW{1'b0}}}
                            : {sr, EMAX - EW'(1), {MW{1'b1}}};
  wire [W-1:0] fin = over ? ovv
                          : {sr, rm[MN-1] ? rex[EW-1:0] : {EW{1'b0}}, rm[MW-1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= {W{1'b0}};
      ovf       <= 1'b0;
      unf       <= 1'b0;
      inx       <= 1'b0;
    end else begin
      out_valid <= v1;
      result    <= spec1 ? specv1 : fin;
      ovf       <= !spec1 && over;
      unf       <= !spec1 && !over && tiny && inexf;
      inx       <= !spec1 && (over || inexf);
    end
endmodule

module fp_add_pipe_chk #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           out_valid,
  input logic [EW+MW:0] result,
  input logic           ovf,
  input logic           unf,
  input logic           inx
);
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};
  wire [EW-1:0] re = result[EW+MW-1:MW];
  wire [MW-1:0] rf = result[MW-1:0];
  logic cv1, cv2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin cv1 <= 1'b0; cv2 <= 1'b0; end
    else        begin cv1 <= in_valid; cv2 <= cv1; end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == cv2);
  assert_ovf_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ovf |-> inx);
  assert_ovf_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ovf |-> ((re == EMAX) && (rf == {MW{1'b0}})) ||
                         ((re == EMAX - EW'(1)) && (rf == {MW{1'b1}})));
  assert_unf_tiny_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && unf |-> inx && (re <= EW'(1)));
  assert_nan_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (re == EMAX) && (rf != {MW{1'b0}}) |-> rf[MW-1] && !ovf && !unf && !inx);
  assert_inf_exact_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (re == EMAX) && (rf == {MW{1'b0}}) && !ovf |-> !inx && !unf);
endmodule

bind fp_add_pipe fp_add_pipe_chk #(.EW(EW), .MW(MW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .ovf(ovf), .unf(unf), .inx(inx));

// File: tb/fp_add_pipe_test.sv
module fp_add_pipe_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] op_a = 8'h00, op_b = 8'h00;
  logic       sub = 1'b0;
  logic [1:0] rnd = 2'd0;
  logic       out_valid, ovf, unf, inx;
  logic [7:0] result;

  fp_add_pipe #(.EW(4), .MW(3)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub(sub), .rnd(rnd), .out_valid(out_valid), .result(result),
    .ovf(ovf), .unf(unf), .inx(inx));

  always #(PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [10:0] q_exp [8];
  int          q_due [8];
  string       q_tag [8];
  int wp = 0, rp = 0, cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // exact reference: every value of the 8-bit format is an integer multiple of 2^-9
  function automatic logic [10:0] ref_add(input logic [7:0] a, input logic [7:0] b,
                                          input logic op, input logic [1:0] md);
    int ea, eb, fa, fb, va, vb, s, m, p, sh, q, rem, half, be;
    logic sa, sb, sg, inc, ix;
    ea = int'(a[6:3]); eb = int'(b[6:3]); fa = int'(a[2:0]); fb = int'(b[2:0]);
    sa = a[7]; sb = b[7] ^ op;
    if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0)) return {8'h7C, 3'b000};
    if (ea == 15 && eb == 15) return (sa != sb) ? {8'h7C, 3'b000} : {sa, 7'h78, 3'b000};
    if (ea == 15) return {sa, 7'h78, 3'b000};
    if (eb == 15) return {sb, 7'h78, 3'b000};
    va = (ea == 0) ? fa : ((fa + 8) << (ea - 1));
    vb = (eb == 0) ? fb : ((fb + 8) << (eb - 1));
    if (sa) va = -va;
    if (sb) vb = -vb;
    s = va + vb;
    if (s == 0) return {((sa == sb) ? sa : (md == 2'd3)), 7'h00, 3'b000};
    sg = (s < 0);
    m = sg ? -s : s;
    if (m < 16) return {sg, 7'(m), 3'b000};
    p = 0;
    for (int i = 0; i < 20; i++) if (m >= (1 << i)) p = i;
    sh = p - 3; q = m >> sh; rem = m - (q << sh); half = 1 << (sh - 1);
    ix = (rem != 0);
    case (md)
      2'd0: inc = (rem > half) || (rem == half && (q % 2) == 1);
      2'd1: inc = 1'b0;
      2'd2: inc = ix && !sg;
      default: inc = ix && sg;
    endcase
    q = q + int'(inc);
    if (q == 16) begin q = 8; sh++; end
    be = sh + 1;
    if (be >= 15)
      return {((md == 2'd0 || (md == 2'd2 && !sg) || (md == 2'd3 && sg)) ? {sg, 7'h78} : {sg, 7'h77}), 3'b101};
    return {sg, 4'(be), 3'(q), 2'b00, ix};
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [7:0] b,
                                   input logic op, input logic [1:0] md, input logic [10:0] e);
    if ((a[6:3] == 4'hF && a[2:0] != 0) || (b[6:3] == 4'hF && b[2:0] != 0)) return "R11";
    if (a[6:3] == 4'hF || b[6:3] == 4'hF) return "R12";
    if (e[2]) return "R8";
    if (e[9:3] == 7'h00 && (a[6:0] != 0 || b[6:0] != 0)) return "R7";
    if (a[6:3] == 0 || b[6:3] == 0) return "R5";
    if (e[9:6] == 0) return "R6";
    if (md != 2'd0) return "R4";
    if (op) return "R2";
    return "R3";
  endfunction

  task automatic check_out();
    if (cnt > 0 && q_due[rp] == cyc) begin
      chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
      chk(result == q_exp[rp][10:3], q_tag[rp], int'(result), int'(q_exp[rp][10:3]));
      chk(ovf == q_exp[rp][2], "R8", int'(ovf), int'(q_exp[rp][2]));
      chk(unf == q_exp[rp][1], "R10", int'(unf), int'(q_exp[rp][1]));
      chk(inx == q_exp[rp][0], "R9", int'(inx), int'(q_exp[rp][0]));
      rp = (rp + 1) % 8; cnt--;
    end else begin
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] b, input logic op, input logic [1:0] md);
    logic [10:0] e;
    @(negedge clk);
    check_out();
    in_valid = 1'b1; op_a = a; op_b = b; sub = op; rnd = md;
    e = ref_add(a, b, op, md);
    q_exp[wp] = e; q_due[wp] = cyc + 2; q_tag[wp] = tag_of(a, b, op, md, e);
    wp = (wp + 1) % 8; cnt++;
  endtask

  task automatic idle();
    @(negedge clk);
    check_out();
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(result == 8'h00, "R1", int'(result), 0);
    // every operand pair, mode and operation varied along the sweep
    for (int i = 0; i < 65536; i++) begin
      logic [7:0] a, b;
      a = 8'(i >> 8); b = 8'(i);
      push(a, b, a[7] ^ b[2] ^ a[0], 2'(a[3:2] + b[1:0]));
      if (i % 97 == 0) idle();
    end
    // high-exponent region under all modes and both operations
    for (int j = 0; j < 64; j++)
      for (int k = 0; k < 64; k++)
        for (int c = 0; c < 8; c++) begin
          logic [7:0] a, b;
          a = {j[5], 4'(11 + (j >> 3) % 4), 3'(j)};
          b = {k[5], 4'(11 + (k >> 3) % 4), 3'(k)};
          push(a, b, c[2], 2'(c));
        end
    repeat (4) idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule